// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Host Controller

This block sits between an on-chip requester and a synchronous burst SRAM. The SRAM registers its address and control on a clock edge and moves the data one cycle later, with no output register. The controller accepts one request per cycle over a valid/ready channel. Each request is a read or a write, with an address, a per-lane byte mask, write data and a burst flag. For every accepted request it puts exactly one command on the memory pins in the next cycle. Commands of either direction follow each other with no idle cycles between them. A one-stage data-phase pipeline drives write data, or samples read data, in the cycle after each command.

Read data returns on a response channel with valid and ready, one response per data beat, in the order the commands were issued. The response channel is the only source of back-pressure. When a response is held (valid high, ready low), the controller raises the memory clock-enable (active low, so high means stall). This freezes the SRAM and the whole command and data pipeline until the response is taken. During that time the request channel is not ready, and no beat is lost or repeated.

A read with the burst flag set becomes one load command and three address-advance commands. The memory walks the beats in the order given by a fixed burst-order pin. Cycles with nothing to issue carry a deselect command, and a data phase already under way still completes.

Top module: `zt_sram_host`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_cs_n is 1, mem_adv_ld is 0, mem_cen_n is 0, mem_dq_oe is 0, and mem_lin_order equals the LINEAR_ORDER parameter (1 = linear, 0 = interleaved).
- R2: A request accepted on an edge (req_valid and req_ready both 1) appears as a load command in the next cycle: mem_adv_ld 0, mem_cs_n 0, mem_addr equal to the request address, and mem_we_n equal to the inverse of req_write.
- R3: A write command drives mem_bw_n to the bitwise inverse of req_be, one bit per lane, with lane l on data bits [l*LANE_W +: LANE_W]. A read command drives all ones on mem_bw_n. mem_dq_oe is 1, with mem_dq_o carrying the write data, exactly in the unstalled cycle after a write command, and is 0 in every other cycle.
- R4: For a read command issued in cycle c, mem_dq_i is sampled in cycle c+1, and rsp_valid is 1 with that data in cycle c+2 (no stall). Responses come back in issue order, one per beat.
- R5: Requests that alternate read and write are accepted on consecutive cycles, with no idle cycle inserted.
- R6: A read with req_burst 1 produces one load command and then three advance commands (mem_adv_ld 1) on consecutive cycles. req_ready is 0 during the load and the first two advances, and 1 during the last advance, so the next load follows without a gap.
- R7: The four burst beats are returned in the memory's burst order from the start address s: linear gives low bits (s+k) mod 4, interleaved gives s XOR k, for k = 0..3.
- R8: A write with req_burst 1 is issued as a single write; no advance command follows and only the addressed word changes.
- R9: A cycle with no command to issue drives a deselect (mem_cs_n 1, mem_adv_ld 0), while a write data phase still under way is still driven.
- R10: While rsp_valid is 1 and rsp_ready is 0, mem_cen_n is 1 and req_ready is 0. The command pins, the data-phase pins and rsp_data all hold, and every beat is delivered once after the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on an edge where valid is also 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | LANES | Byte-lane write mask, 1 = write the lane |
| req_wdata | input | LANES*LANE_W | Write data |
| req_burst | input | 1 | Four-beat burst (reads only) |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response taken; 0 stalls the controller |
| rsp_data | output | LANES*LANE_W | Read data |
| mem_cen_n | output | 1 | Memory clock enable, active low |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_adv_ld | output | 1 | 0 = load new address, 1 = advance burst |
| mem_we_n | output | 1 | 0 = write, 1 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_bw_n | output | LANES | Byte-lane write selects, active low |
| mem_lin_order | output | 1 | Burst order: 1 linear, 0 interleaved |
| mem_dq_o | output | LANES*LANE_W | Write data to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | LANES*LANE_W | Read data from the memory |

## Verification
The bench builds the controller with a 6-bit address, two 8-bit lanes and interleaved burst order, against a behavioural flow-through SRAM model of 64 words. The short address lets a 64-entry model cover every address used, and two lanes are enough to show a partial byte mask. Interleaved order, started from an odd address, gives a beat sequence that differs from linear order, so a wrong beat order shows up in the returned data. The stall test holds a response in the middle of a burst, which brings the frozen pipeline and the order of the beats released afterwards within reach.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  // Kind of data phase that follows a command by one cycle.
  typedef enum logic [1:0] {
    PH_NONE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/zt_burst_ctr.sv
module zt_burst_ctr #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  output logic busy
);
  localparam int CW = (BEATS > 2) ? $clog2(BEATS) : 1;

  // Number of advance commands still to issue.
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (en) begin
      if (start) begin
        left_q <= CW'(BEATS - 1);
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/zt_cmd_issue.sv
module zt_cmd_issue
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      acc,
  input  logic                      acc_write,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [LANES-1:0]          acc_be,
  input  logic [LANES*LANE_W-1:0]   acc_wdata,
  input  logic                      cont,
  output logic                      cs_n,
  output logic                      adv_ld,
  output logic                      we_n,
  output logic [ADDR_W-1:0]         addr,
  output logic [LANES-1:0]          bw_n,
  output phase_e                    ph,
  output logic [LANES*LANE_W-1:0]   ph_wdata
);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0] lane_bw_n;

  // Reads keep every lane select high; writes follow the mask lane by lane.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bw_n[l] = ~(acc_write & acc_be[l]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n     <= 1'b1;
      adv_ld   <= 1'b0;
      we_n     <= 1'b1;
      addr     <= '0;
      bw_n     <= '1;
      ph       <= PH_NONE;
      ph_wdata <= '0;
    end else if (en) begin
      if (acc) begin
        cs_n     <= 1'b0;
        adv_ld   <= 1'b0;
        we_n     <= ~acc_write;
        addr     <= acc_addr;
        bw_n     <= lane_bw_n;
        ph       <= acc_write ? PH_WRITE : PH_READ;
        ph_wdata <= acc_wdata;
      end else if (cont) begin
        // Burst continuation: the memory steps its own address.
        cs_n     <= 1'b0;
        adv_ld   <= 1'b1;
        we_n     <= 1'b1;
        bw_n     <= '1;
        ph       <= PH_READ;
        ph_wdata <= DATA_W'(0);
      end else begin
        cs_n     <= 1'b1;
        adv_ld   <= 1'b0;
        we_n     <= 1'b1;
        bw_n     <= '1;
        ph       <= PH_NONE;
        ph_wdata <= DATA_W'(0);
      end
    end
  end
endmodule

// File: rtl/zt_data_phase.sv
module zt_data_phase
  import zt_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  phase_e            ph_in,
  input  logic [DATA_W-1:0] wd_in,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  phase_e            dph_q;
  logic [DATA_W-1:0] dwd_q;

  // One-stage pipeline: the data phase trails its command by a cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dph_q <= PH_NONE;
      dwd_q <= '0;
    end else if (en) begin
      dph_q <= ph_in;
      dwd_q <= wd_in;
    end
  end

  assign dq_oe = (dph_q == PH_WRITE);
  assign dq_o  = dwd_q;

  // Read data is captured at the end of its data phase.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (en) begin
      rsp_valid <= (dph_q == PH_READ);
      if (dph_q == PH_READ) begin
        rsp_data <= dq_i;
      end
    end
  end
endmodule

// File: rtl/zt_sram_host.sv
module zt_sram_host
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int LANES        = 4,
  parameter int LANE_W       = 9,
  parameter int BURST_LEN    = 4,
  parameter int LINEAR_ORDER = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES-1:0]        req_be,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic                    req_burst,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [LANES*LANE_W-1:0] rsp_data,
  output logic                    mem_cen_n,
  output logic                    mem_cs_n,
  output logic                    mem_adv_ld,
  output logic                    mem_we_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANES-1:0]        mem_bw_n,
  output logic                    mem_lin_order,
  output logic [LANES*LANE_W-1:0] mem_dq_o,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_i
);
  localparam int DATA_W = LANES * LANE_W;

  logic              stall;
  logic              run;
  logic              busy;
  logic              acc;
  logic              burst_go;
  phase_e            ph;
  logic [DATA_W-1:0] ph_wdata;

  // A held response freezes the memory and every pipeline register.
  assign stall     = rsp_valid & ~rsp_ready;
  assign run       = ~stall;
  assign mem_cen_n = stall;
  assign req_ready = run & ~busy;
  assign acc       = req_valid & req_ready;
  assign burst_go  = acc & req_burst & ~req_write;

  assign mem_lin_order = (LINEAR_ORDER != 0);

  zt_burst_ctr #(.BEATS(BURST_LEN)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run),
    .start (burst_go),
    .busy  (busy)
  );

  zt_cmd_issue #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (run),
    .acc       (acc),
    .acc_write (req_write),
    .acc_addr  (req_addr),
    .acc_be    (req_be),
    .acc_wdata (req_wdata),
    .cont      (busy),
    .cs_n      (mem_cs_n),
    .adv_ld    (mem_adv_ld),
    .we_n      (mem_we_n),
    .addr      (mem_addr),
    .bw_n      (mem_bw_n),
    .ph        (ph),
    .ph_wdata  (ph_wdata)
  );

  zt_data_phase #(.DATA_W(DATA_W)) u_dphase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (run),
    .ph_in     (ph),
    .wd_in     (ph_wdata),
    .dq_i      (mem_dq_i),
    .dq_o      (mem_dq_o),
    .dq_oe     (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/zt_sram_host_chk.sv
module zt_sram_host_chk #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_write,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [LANES*LANE_W-1:0] rsp_data,
  input logic                    mem_cen_n,
  input logic                    mem_cs_n,
  input logic                    mem_adv_ld,
  input logic                    mem_we_n,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    mem_dq_oe
);
  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (mem_cen_n && !req_ready));

  // R10
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(mem_addr)
      && $stable(mem_adv_ld) && $stable(mem_cs_n) && $stable(mem_we_n) && $stable(mem_dq_oe)));

  // R2
  issue_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_adv_ld && !mem_cs_n
      && mem_addr == $past(req_addr) && mem_we_n == !$past(req_write)));

  // R3
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cen_n && !mem_cs_n && !mem_adv_ld && !mem_we_n) |=> mem_dq_oe);

  // R3
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cen_n && (mem_cs_n || mem_adv_ld || mem_we_n)) |=> !mem_dq_oe);

  // R4
  rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cen_n && !mem_cs_n && !mem_adv_ld && mem_we_n) ##1 !mem_cen_n |=> rsp_valid);

  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !mem_adv_ld ##1 !mem_adv_ld);
endmodule

bind zt_sram_host zt_sram_host_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .mem_cen_n  (mem_cen_n),
  .mem_cs_n   (mem_cs_n),
  .mem_adv_ld (mem_adv_ld),
  .mem_we_n   (mem_we_n),
  .mem_addr   (mem_addr),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/zt_sram_host_tb.sv
`timescale 1ns/1ps
module zt_sram_host_tb_top;
  localparam int AW  = 6;
  localparam int NL  = 2;
  localparam int LW  = 8;
  localparam int DW  = NL * LW;
  localparam int LIN = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [NL-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, mem_cen_n, mem_cs_n, mem_adv_ld, mem_we_n;
  logic          mem_lin_order, mem_dq_oe;
  logic [DW-1:0] rsp_data, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;
  logic [NL-1:0] mem_bw_n;

  zt_sram_host #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .BURST_LEN(4), .LINEAR_ORDER(LIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_burst(req_burst), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_cen_n(mem_cen_n), .mem_cs_n(mem_cs_n), .mem_adv_ld(mem_adv_ld), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_bw_n(mem_bw_n), .mem_lin_order(mem_lin_order),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // ---- behavioural flow-through burst SRAM ----
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          pv, pw;
  logic [AW-1:0] pa, base;
  logic [1:0]    bcnt;
  logic [NL-1:0] pbw;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] k);
    logic [1:0] lo;
    lo = (LIN != 0) ? 2'(b[1:0] + k) : (b[1:0] ^ k);
    return {b[AW-1:2], lo};
  endfunction

  assign mem_dq_i = (pv && !pw) ? mem[pa] : '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pv <= 1'b0; pw <= 1'b0; pa <= '0; base <= '0; bcnt <= '0; pbw <= '1;
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
    end else if (!mem_cen_n) begin
      if (pv && pw && mem_dq_oe)
        for (int l = 0; l < NL; l++)
          if (!pbw[l]) mem[pa][l*LW +: LW] <= mem_dq_o[l*LW +: LW];
      if (!mem_adv_ld) begin
        pv <= !mem_cs_n; pw <= !mem_we_n; pa <= mem_addr; base <= mem_addr;
        bcnt <= '0; pbw <= mem_bw_n;
      end else begin
        bcnt <= 2'(bcnt + 2'd1);
        pa   <= beat_addr(base, 2'(bcnt + 2'd1));
        pbw  <= '1;
      end
    end
  end

  // ---- bookkeeping ----
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] rq[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) rq.push_back(rsp_data);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  int acc_cyc;
  task automatic send(input bit w, input logic [AW-1:0] a, input logic [NL-1:0] be,
                      input logic [DW-1:0] d, input bit b);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d; req_burst = b;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc;
  endtask

  task automatic quiet();
    @(negedge clk); req_valid = 1'b0; #1;
  endtask

  task automatic wait_rsp(input int n);
    for (int i = 0; i < 40 && rq.size() < n; i++) at_neg();
  endtask

  function automatic logic [DW-1:0] pre(input int i);
    return DW'(16'h1000 + i * 16'h0111);
  endfunction

  // ---- scenarios ----
  task automatic t_reset();
    at_neg();
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_cs_n == 1'b1 && mem_adv_ld == 1'b0, "R1 deselect", {mem_cs_n, mem_adv_ld}, 2'b10);
    chk(mem_cen_n == 1'b0 && mem_dq_oe == 1'b0, "R1 cen/oe", {mem_cen_n, mem_dq_oe}, 0);
    chk(mem_lin_order == 1'(LIN), "R1 order pin", mem_lin_order, LIN);
  endtask

  task automatic t_single();
    send(1, 6'd5, 2'b11, 16'hA5C3, 0); quiet();
    chk(!mem_cs_n && !mem_adv_ld && !mem_we_n, "R2 write load", {mem_cs_n, mem_adv_ld, mem_we_n}, 0);
    chk(mem_addr == 6'd5, "R2 addr", mem_addr, 5);
    chk(mem_bw_n == 2'b00, "R3 bw_n write", mem_bw_n, 0);
    chk(mem_dq_oe == 1'b0, "R3 oe in command cycle", mem_dq_oe, 0);
    at_neg();
    chk(mem_dq_oe == 1'b1 && mem_dq_o == 16'hA5C3, "R3 write data", mem_dq_o, 16'hA5C3);
    chk(mem_cs_n == 1'b1 && mem_adv_ld == 1'b0, "R9 deselect during data phase", mem_cs_n, 1);
    at_neg();
    chk(mem_dq_oe == 1'b0, "R3 oe released", mem_dq_oe, 0);
    rq.delete();
    send(0, 6'd5, 2'b11, '0, 0); quiet();
    chk(mem_we_n == 1'b1 && mem_bw_n == 2'b11, "R3 read bw_n", mem_bw_n, 3);
    at_neg();
    chk(rsp_valid == 1'b0, "R4 no early rsp", rsp_valid, 0);
    at_neg();
    chk(rsp_valid == 1'b1 && rsp_data == 16'hA5C3, "R4 read return", rsp_data, 16'hA5C3);
    at_neg();
  endtask

  task automatic t_mask();
    send(1, 6'd9, 2'b11, 16'h1234, 0);
    send(1, 6'd9, 2'b01, 16'hABCD, 0); quiet();
    chk(mem_bw_n == 2'b10, "R3 partial bw_n", mem_bw_n, 2);
    rq.delete();
    send(0, 6'd9, 2'b11, '0, 0); quiet();
    wait_rsp(1);
    chk(rq.size() == 1 && rq[0] == 16'h12CD, "R3 lane merge", rq.size() ? rq[0] : 0, 16'h12CD);
  endtask

  task automatic t_alternate();
    int c[6];
    rq.delete();
    send(1, 6'd10, 2'b11, 16'h1111, 0); c[0] = acc_cyc;
    send(0, 6'd10, 2'b11, '0, 0);       c[1] = acc_cyc;
    send(1, 6'd11, 2'b11, 16'h2222, 0); c[2] = acc_cyc;
    send(0, 6'd11, 2'b11, '0, 0);       c[3] = acc_cyc;
    send(1, 6'd10, 2'b11, 16'h3333, 0); c[4] = acc_cyc;
    send(0, 6'd10, 2'b11, '0, 0);       c[5] = acc_cyc;
    quiet();
    for (int i = 1; i < 6; i++) chk(c[i] == c[i-1] + 1, "R5 back-to-back", c[i] - c[i-1], 1);
    wait_rsp(3);
    chk(rq.size() == 3, "R5 rsp count", rq.size(), 3);
    if (rq.size() == 3) begin
      chk(rq[0] == 16'h1111, "R5 read after write 0", rq[0], 16'h1111);
      chk(rq[1] == 16'h2222, "R5 read after write 1", rq[1], 16'h2222);
      chk(rq[2] == 16'h3333, "R5 read after write 2", rq[2], 16'h3333);
    end
  endtask

  task automatic preload();
    for (int i = 0; i < 4; i++) send(1, 6'(6'h20 + i), 2'b11, pre(i), 0);
    quiet(); at_neg();
  endtask

  task automatic t_burst();
    preload();
    rq.delete();
    send(0, 6'h21, 2'b11, '0, 1); quiet();
    chk(!mem_adv_ld && mem_addr == 6'h21, "R6 burst load", mem_addr, 6'h21);
    chk(req_ready == 1'b0, "R6 ready low at load", req_ready, 0);
    for (int k = 1; k <= 3; k++) begin
      at_neg();
      chk(mem_adv_ld == 1'b1, "R6 advance", mem_adv_ld, 1);
      chk(req_ready == (k == 3), "R6 ready during advance", req_ready, k == 3);
    end
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h20; req_burst = 1'b0;
    quiet();
    chk(!mem_adv_ld && !mem_cs_n && mem_addr == 6'h20, "R6 load right after burst", mem_addr, 6'h20);
    wait_rsp(5);
    chk(rq.size() == 5, "R7 beat count", rq.size(), 5);
    if (rq.size() == 5) begin
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] ea;
        ea = beat_addr(6'h21, 2'(k));
        chk(rq[k] == pre(int'(ea[1:0])), "R7 beat order", rq[k], pre(int'(ea[1:0])));
      end
      chk(rq[4] == pre(0), "R4 issue order after burst", rq[4], pre(0));
    end
  endtask

  task automatic t_wr_burst();
    send(1, 6'h31, 2'b11, 16'h5555, 0);
    send(1, 6'h30, 2'b11, 16'h7777, 1); quiet();
    chk(!mem_adv_ld && req_ready, "R8 single write load", {mem_adv_ld, req_ready}, 1);
    at_neg();
    chk(!mem_adv_ld && mem_cs_n, "R8 no advance after write", {mem_adv_ld, mem_cs_n}, 1);
    rq.delete();
    send(0, 6'h31, 2'b11, '0, 0);
    send(0, 6'h30, 2'b11, '0, 0); quiet();
    wait_rsp(2);
    chk(rq.size() == 2 && rq[0] == 16'h5555, "R8 neighbour untouched", rq.size() ? rq[0] : 0, 16'h5555);
    chk(rq.size() == 2 && rq[1] == 16'h7777, "R8 addressed word", rq.size() > 1 ? rq[1] : 0, 16'h7777);
  endtask

  task automatic t_stall();
    logic [DW-1:0] held;
    rq.delete();
    @(negedge clk); rsp_ready = 1'b0;
    send(0, 6'h21, 2'b11, '0, 1); quiet();
    at_neg(); at_neg();
    chk(rsp_valid == 1'b1, "R10 rsp pending", rsp_valid, 1);
    chk(mem_cen_n == 1'b1 && req_ready == 1'b0, "R10 stall pins", {mem_cen_n, req_ready}, 2'b10);
    held = rsp_data;
    for (int i = 0; i < 3; i++) begin
      at_neg();
      chk(rsp_valid && rsp_data == held, "R10 rsp held", rsp_data, held);
      chk(mem_cen_n && mem_adv_ld, "R10 frozen advance", {mem_cen_n, mem_adv_ld}, 2'b11);
    end
    @(negedge clk); rsp_ready = 1'b1;
    wait_rsp(4);
    chk(rq.size() == 4, "R10 beat count after stall", rq.size(), 4);
    if (rq.size() == 4)
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] ea;
        ea = beat_addr(6'h21, 2'(k));
        chk(rq[k] == pre(int'(ea[1:0])), "R10 beat after stall", rq[k], pre(int'(ea[1:0])));
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_mask();
    t_alternate();
    t_burst();
    t_wr_burst();
    t_stall();
    repeat (4) at_neg();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule